// File: doc/BRIEF.md
# Source-Synchronous Transmit Sample Serializer

This block sits between user logic that produces I/Q sample pairs and the per-lane parallel inputs of the output serializers of a source-synchronous transmit data port. It paces the user side with a one-cycle fetch strobe. On the clock edge where the strobe is high, it captures one 16-bit I and 16-bit Q pair. Over the clocks that follow, it hands the captured bits out as bit groups, one group per active lane per clock.

The block is configured by five inputs. A lane-count select chooses one, two or four lanes. A single-rate/double-rate flag sets 4 or 8 bits per lane per clock. A symbol-format enable and a narrow-symbol select cut the sample down to 16 or 8 bits. An 8-bit rate value sets how many user clocks make one sample period. Software must set the rate to the number of clocks the chosen format needs. For example, the rate is 8 for one lane at single rate with full samples, and 1 for four lanes at double rate. If the rate is larger than needed, the spare clocks carry zeros.

Top module: `ssi_tx_serializer`

## Requirements
- R1: While `rst_ni` is low, and in the first cycle after it is released, `fetch_o`, `frame_o` and `lane_data_o` are all zero.
- R2: `fetch_o` is high for exactly one cycle in every `rate_i` cycles. A `rate_i` of 0 acts as 1. The first strobe appears after `rate_i` rising edges following the release of reset.
- R3: The I/Q pair present at the rising edge where `fetch_o` is high is captured. `frame_o` is high in the next cycle, together with the first bit group of that pair, and `frame_o` is low in every other cycle.
- R4: The sample bit stream is `i_data_i[15:0]` followed by `q_data_i[15:0]`, most significant bit first. Each clock takes the next (lanes × group) bits. Lane 0 carries the most significant group, and lane k appears on `lane_data_o[8k+7:8k]`.
- R5: A `lanes_i` of 2 selects two lanes and 4 selects four lanes. Any other value selects one lane. The fields of inactive lanes are zero.
- R6: With `sdr_i`=1, each lane carries 4 bits per clock in field bits [7:4], and bits [3:0] are zero. With `sdr_i`=0, each lane carries 8 bits per clock.
- R7: With `sym_en_i`=1 and `sym8_i`=0, only the 16 bits of I are sent. With `sym_en_i`=1 and `sym8_i`=1, only `i_data_i[15:8]` is sent. With `sym_en_i`=0, all 32 bits are sent.
- R8: When `rate_i` exceeds the clocks the format needs, the groups after the sample's last bit are zero until the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | User interface clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| lanes_i | input | 3 | Lane count select (2, 4, otherwise one lane) |
| sdr_i | input | 1 | 1: single rate, 0: double rate |
| sym_en_i | input | 1 | Enables reduced symbol formats |
| sym8_i | input | 1 | Narrow symbol select (8-bit when set) |
| rate_i | input | 8 | User clocks per sample period |
| i_data_i | input | 16 | In-phase sample word |
| q_data_i | input | 16 | Quadrature sample word |
| fetch_o | output | 1 | Sample fetch strobe to user logic |
| frame_o | output | 1 | Marks the first bit group of a sample |
| lane_data_o | output | 32 | Per-lane bit groups, 8 bits per lane |

## Verification
The bench walks a table of configurations, one for each matched format: one lane at single and double rate, two lanes at both rates, and four lanes at both rates. This table tells the group order and lane assignment apart, because a swapped lane or a wrong step size moves bits to a visibly different field. Further rows cover both reduced symbol formats, to separate the cases that drop Q from those that also drop the low half of I. Other rows use an oversized rate to expose zero fill, an unsupported lane code to expose the one-lane fallback, and a rate of zero. Directed tests then measure the latency of the first strobe after reset and check the outputs during and just after reset.

// File: rtl/ssi_tx_pkg.sv
package ssi_tx_pkg;

  typedef enum logic [1:0] {
    FMT_IQ32  = 2'd0,
    FMT_SYM16 = 2'd1,
    FMT_SYM8  = 2'd2
  } sym_fmt_e;

  // Lane count from the select code: 2 and 4 are honoured, all else is one lane.
  function automatic logic [2:0] decode_lanes(input logic [2:0] sel);
    logic [2:0] n;
    case (sel)
      3'd2:    n = 3'd2;
      3'd4:    n = 3'd4;
      default: n = 3'd1;
    endcase
    return n;
  endfunction

  function automatic sym_fmt_e pick_fmt(input logic en, input logic narrow);
    sym_fmt_e f;
    if (!en)        f = FMT_IQ32;
    else if (narrow) f = FMT_SYM8;
    else            f = FMT_SYM16;
    return f;
  endfunction

endpackage

// File: rtl/ssi_rate_pacer.sv
module ssi_rate_pacer #(
  parameter int RATE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [RATE_W-1:0] rate_i,
  output logic              fetch_o
);

  logic              run_q, run_d;
  logic [RATE_W-1:0] cnt_q, cnt_d;
  logic [RATE_W-1:0] last;
  logic              wrap;

  always_comb begin
    last  = (rate_i == '0) ? '0 : rate_i - RATE_W'(1);
    wrap  = (cnt_q >= last);
    run_d = 1'b1;
    cnt_d = cnt_q;
    if (run_q) begin
      cnt_d = wrap ? '0 : cnt_q + RATE_W'(1);
    end
  end

  assign fetch_o = run_q & wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      run_q <= run_d;
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/ssi_sample_packer.sv
module ssi_sample_packer
  import ssi_tx_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  localparam int FRAME_W = 2 * SAMPLE_W,
  localparam int HALF_W  = SAMPLE_W / 2
) (
  input  logic [SAMPLE_W-1:0] i_data_i,
  input  logic [SAMPLE_W-1:0] q_data_i,
  input  logic                sym_en_i,
  input  logic                sym8_i,
  output logic [FRAME_W-1:0]  frame_o
);

  sym_fmt_e fmt;

  always_comb begin
    fmt = pick_fmt(sym_en_i, sym8_i);
    unique case (fmt)
      FMT_SYM16: frame_o = {i_data_i, {SAMPLE_W{1'b0}}};
      FMT_SYM8:  frame_o = {i_data_i[SAMPLE_W-1 -: HALF_W], {(FRAME_W-HALF_W){1'b0}}};
      default:   frame_o = {i_data_i, q_data_i};
    endcase
  end

endmodule

// File: rtl/ssi_lane_shifter.sv
module ssi_lane_shifter #(
  parameter int FRAME_W   = 32,
  parameter int LANES_MAX = 4,
  parameter int LANE_W    = 8,
  localparam int HALF_W   = LANE_W / 2,
  localparam int STEP_W   = $clog2(FRAME_W + 1),
  localparam int OUT_W    = LANES_MAX * LANE_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [FRAME_W-1:0] frame_i,
  input  logic [2:0]         nlanes_i,
  input  logic               sdr_i,
  output logic [OUT_W-1:0]   lane_data_o,
  output logic               first_o
);

  logic [FRAME_W-1:0] shreg_q, shreg_d;
  logic               first_q, first_d;
  logic [STEP_W-1:0]  grp;
  logic [STEP_W-1:0]  step;

  always_comb begin
    grp     = sdr_i ? STEP_W'(HALF_W) : STEP_W'(LANE_W);
    step    = STEP_W'(nlanes_i) * grp;
    first_d = load_i;
    shreg_d = load_i ? frame_i : (shreg_q << step);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shreg_q <= '0;
      first_q <= 1'b0;
    end else begin
      shreg_q <= shreg_d;
      first_q <= first_d;
    end
  end

  assign first_o = first_q;

  for (genvar k = 0; k < LANES_MAX; k++) begin : g_lane
    logic [STEP_W-1:0]  off;
    logic [FRAME_W-1:0] aligned;
    logic [LANE_W-1:0]  field;

    always_comb begin
      off     = STEP_W'(k) * grp;
      aligned = shreg_q << off;
      if (k >= int'(nlanes_i)) begin
        field = '0;
      end else if (sdr_i) begin
        field = {aligned[FRAME_W-1 -: HALF_W], {HALF_W{1'b0}}};
      end else begin
        field = aligned[FRAME_W-1 -: LANE_W];
      end
    end

    assign lane_data_o[k*LANE_W +: LANE_W] = field;
  end

endmodule

// File: rtl/ssi_tx_serializer.sv
module ssi_tx_serializer
  import ssi_tx_pkg::*;
#(
  parameter int SAMPLE_W  = 16,
  parameter int LANES_MAX = 4,
  parameter int LANE_W    = 8,
  parameter int RATE_W    = 8,
  localparam int FRAME_W  = 2 * SAMPLE_W,
  localparam int OUT_W    = LANES_MAX * LANE_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [2:0]          lanes_i,
  input  logic                sdr_i,
  input  logic                sym_en_i,
  input  logic                sym8_i,
  input  logic [RATE_W-1:0]   rate_i,
  input  logic [SAMPLE_W-1:0] i_data_i,
  input  logic [SAMPLE_W-1:0] q_data_i,
  output logic                fetch_o,
  output logic                frame_o,
  output logic [OUT_W-1:0]    lane_data_o
);

  logic               fetch;
  logic [FRAME_W-1:0] packed_smp;
  logic [2:0]         nlanes;

  assign nlanes = decode_lanes(lanes_i);

  ssi_rate_pacer #(
    .RATE_W (RATE_W)
  ) u_pacer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rate_i  (rate_i),
    .fetch_o (fetch)
  );

  ssi_sample_packer #(
    .SAMPLE_W (SAMPLE_W)
  ) u_packer (
    .i_data_i (i_data_i),
    .q_data_i (q_data_i),
    .sym_en_i (sym_en_i),
    .sym8_i   (sym8_i),
    .frame_o  (packed_smp)
  );

  ssi_lane_shifter #(
    .FRAME_W   (FRAME_W),
    .LANES_MAX (LANES_MAX),
    .LANE_W    (LANE_W)
  ) u_shifter (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (fetch),
    .frame_i     (packed_smp),
    .nlanes_i    (nlanes),
    .sdr_i       (sdr_i),
    .lane_data_o (lane_data_o),
    .first_o     (frame_o)
  );

  assign fetch_o = fetch;

endmodule

// File: rtl/ssi_tx_serializer_chk.sv
module ssi_tx_serializer_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [2:0]  lanes_i,
  input logic        sdr_i,
  input logic [7:0]  rate_i,
  input logic        fetch_o,
  input logic        frame_o,
  input logic [31:0] lane_data_o
);

  logic [8:0] gap_q;
  logic       armed_q;
  logic       chg_q;
  logic [7:0] rate_prev_q;
  logic [8:0] eff;
  logic       rate_diff;

  assign eff       = (rate_i == 8'd0) ? 9'd1 : {1'b0, rate_i};
  assign rate_diff = (rate_i != rate_prev_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q       <= 9'd0;
      armed_q     <= 1'b0;
      chg_q       <= 1'b0;
      rate_prev_q <= 8'd0;
    end else begin
      rate_prev_q <= rate_i;
      if (fetch_o) begin
        gap_q   <= 9'd1;
        armed_q <= 1'b1;
        chg_q   <= rate_diff;
      end else begin
        if (gap_q != 9'h1FF) gap_q <= gap_q + 9'd1;
        if (rate_diff) chg_q <= 1'b1;
      end
    end
  end

  assert_fetch_spacing_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fetch_o && armed_q && !chg_q && !rate_diff) |-> (gap_q == eff));

  assert_frame_after_fetch_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_o |=> frame_o);

  assert_frame_has_fetch_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_o |-> $past(fetch_o));

  assert_idle_lanes_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((lanes_i != 3'd2) && (lanes_i != 3'd4)) |-> (lane_data_o[31:8] == 24'd0));

  assert_two_lane_upper_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lanes_i == 3'd2) |-> (lane_data_o[31:16] == 16'd0));

  assert_sdr_low_nibble_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sdr_i |-> ((lane_data_o & 32'h0F0F_0F0F) == 32'd0));

endmodule

bind ssi_tx_serializer ssi_tx_serializer_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .lanes_i     (lanes_i),
  .sdr_i       (sdr_i),
  .rate_i      (rate_i),
  .fetch_o     (fetch_o),
  .frame_o     (frame_o),
  .lane_data_o (lane_data_o)
);

// File: tb/ssi_tx_serializer_tb.sv
module ssi_tx_serializer_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  lanes = 3'd1;
  logic        sdr = 1'b1;
  logic        sym_en = 1'b0;
  logic        sym8 = 1'b0;
  logic [7:0]  rate = 8'd8;
  logic [15:0] i_d = 16'd0;
  logic [15:0] q_d = 16'd0;
  logic        fetch;
  logic        frame;
  logic [31:0] lane_out;

  int checks = 0;
  int errors = 0;
  int seq = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  ssi_tx_serializer u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .lanes_i     (lanes),
    .sdr_i       (sdr),
    .sym_en_i    (sym_en),
    .sym8_i      (sym8),
    .rate_i      (rate),
    .i_data_i    (i_d),
    .q_data_i    (q_d),
    .fetch_o     (fetch),
    .frame_o     (frame),
    .lane_data_o (lane_out)
  );

  // {lane select, sdr, symbol enable, narrow symbol, rate}
  localparam int NV = 13;
  localparam logic [13:0] VEC [NV] = '{
    {3'd1, 1'b1, 1'b0, 1'b0, 8'd8},
    {3'd1, 1'b0, 1'b0, 1'b0, 8'd4},
    {3'd2, 1'b1, 1'b0, 1'b0, 8'd4},
    {3'd2, 1'b0, 1'b0, 1'b0, 8'd2},
    {3'd4, 1'b1, 1'b0, 1'b0, 8'd2},
    {3'd4, 1'b0, 1'b0, 1'b0, 8'd1},
    {3'd1, 1'b1, 1'b1, 1'b0, 8'd4},
    {3'd1, 1'b0, 1'b1, 1'b0, 8'd2},
    {3'd1, 1'b1, 1'b1, 1'b1, 8'd2},
    {3'd1, 1'b0, 1'b1, 1'b1, 8'd1},
    {3'd1, 1'b1, 1'b0, 1'b0, 8'd10},
    {3'd3, 1'b0, 1'b0, 1'b0, 8'd4},
    {3'd4, 1'b0, 1'b0, 1'b0, 8'd0}
  };

  function automatic logic [31:0] pack_ref(logic [15:0] iv, logic [15:0] qv,
                                           logic en, logic narrow);
    if (!en) return {iv, qv};
    if (narrow) return {iv[15:8], 24'h0};
    return {iv, 16'h0};
  endfunction

  function automatic logic [7:0] lane_ref(logic [31:0] p, int g, int k, int nl, logic s);
    int gw = s ? 4 : 8;
    int sh = g * nl * gw + k * gw;
    logic [31:0] t;
    if (k >= nl) return 8'h00;
    t = (sh >= 32) ? 32'h0 : (p << sh);
    return s ? {t[31:28], 4'h0} : t[31:24];
  endfunction

  task automatic check(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic next_data();
    seq++;
    i_d = 16'(seq * 40503 + 7);
    q_d = 16'((seq * 2654) ^ 16'hC3A5);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check(fetch == 1'b0 && frame == 1'b0 && lane_out == 32'h0, "R1", "in reset",
          {lane_out[29:0], fetch, frame}, 32'h0);
    rst_n = 1'b1;
  endtask

  task automatic run_cfg(logic [13:0] v);
    int nl, eff, gw, bits, need, guard;
    string tag;
    logic [31:0] p, p_next;
    logic [7:0] exp_l;
    lanes  = v[13:11];
    sdr    = v[10];
    sym_en = v[9];
    sym8   = v[8];
    rate   = v[7:0];
    nl   = (lanes == 3'd4) ? 4 : ((lanes == 3'd2) ? 2 : 1);
    eff  = (rate == 8'd0) ? 1 : int'(rate);
    gw   = sdr ? 4 : 8;
    bits = !sym_en ? 32 : (sym8 ? 8 : 16);
    need = (bits + nl * gw - 1) / (nl * gw);
    if (sym_en) tag = "R7";
    else if (eff > need) tag = "R8";
    else if (lanes != 3'd1 && lanes != 3'd2 && lanes != 3'd4) tag = "R5";
    else if (sdr) tag = "R6";
    else tag = "R4";
    do_reset();
    p = 32'h0;
    guard = 0;
    while (guard < 300) begin
      @(negedge clk);
      next_data();
      if (fetch) break;
      guard++;
    end
    p = pack_ref(i_d, q_d, sym_en, sym8);
    p_next = p;
    for (int s = 0; s < 3; s++) begin
      for (int g = 0; g < eff; g++) begin
        @(negedge clk);
        check(frame == (g == 0), "R3", "frame flag", {31'h0, frame}, {31'h0, g == 0});
        check(fetch == (g == eff - 1), "R2", "fetch strobe", {31'h0, fetch}, {31'h0, g == eff - 1});
        for (int k = 0; k < 4; k++) begin
          exp_l = lane_ref(p, g, k, nl, sdr);
          check(lane_out[k*8 +: 8] == exp_l, (k >= nl) ? "R5" : tag, "lane field",
                {24'h0, lane_out[k*8 +: 8]}, {24'h0, exp_l});
        end
        next_data();
        if (fetch) p_next = pack_ref(i_d, q_d, sym_en, sym8);
      end
      p = p_next;
    end
  endtask

  task automatic first_fetch_latency(logic [7:0] r, int exp_n);
    int n = 0;
    lanes = 3'd1;
    sdr = 1'b1;
    sym_en = 1'b0;
    sym8 = 1'b0;
    rate = r;
    do_reset();
    @(negedge clk);
    n = 1;
    check(frame == 1'b0 && lane_out == 32'h0, "R1", "first cycle after reset",
          {lane_out[30:0], frame}, 32'h0);
    while (!fetch && n < 300) begin
      @(negedge clk);
      n++;
    end
    check(n == exp_n, "R2", "first fetch latency", n, exp_n);
  endtask

  initial begin
    for (int v = 0; v < NV; v++) begin
      run_cfg(VEC[v]);
    end
    first_fetch_latency(8'd8, 8);
    first_fetch_latency(8'd3, 3);
    first_fetch_latency(8'd0, 1);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #600us;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog timeout actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule